// File: doc/BRIEF.md
# Prioritized Level Interrupt Hub

This block gathers level-sensitive interrupt requests from a set of peripheral sources and drives a single interrupt line to a processor. Each source has a fixed numeric ID, equal to its index. Each source also has its own enable bit and an 8-bit priority. A smaller priority number is more urgent. Software programs the block through a simple synchronous register bus. The bus has no back-pressure: a write takes effect at the clock edge where it is sampled, and read data appears registered on the following cycle.

To service an interrupt, the handler reads the acknowledge register. The read returns the ID of the winning source and marks that source active. The handler finishes by writing the same ID to the end-of-interrupt register. A source whose request is still high after that write is signalled again. While a source is active, only strictly more urgent sources can raise the line. This allows nesting. A global priority mask and a CPU-interface enable bit gate every delivery.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset the interrupt output is low. Control, mask, source-enable and priority registers all read 0, and no source is active.
- R2: The interrupt output can be high only while bit 0 of the control register (word address 0) is 1. When that bit is 0, an acknowledge read returns 1023 and changes nothing.
- R3: A source is eligible only when its priority is strictly smaller than the mask register (word address 1, bits 7:0).
- R4: A source is eligible only while its bit in the source-enable register (word address 4, bit i for source i) is 1 and its request input is high.
- R5: Among the eligible sources, the one with the smallest priority value wins, and ties go to the lowest ID. A read of word address 2 returns the winner's ID in bits 9:0.
- R6: An acknowledge read makes the winner active. While any source is active, a source is eligible only if its priority is strictly smaller than the smallest priority among the active sources. Active sources are never eligible.
- R7: An acknowledge read with no eligible source returns 1023 and leaves the state unchanged.
- R8: Writing an ID to word address 3 clears that source's active state. If its request is still high, the source is signalled again. An ID that is not active, or not a valid source, has no effect.
- R9: Priority for source i is at word address 32+i, bits 7:0. Every configuration register reads back what was written. Unmapped addresses read 0.
- R10: Read data is registered, so it is valid on the cycle after the read enable. The interrupt output is registered and follows the state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_SRC | Level requests, bit i is source ID i |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the hub with NUM_SRC set to 6 and the default 8-bit priority. This leaves priority slots 38 and above unmapped, so the bench can check that they read 0. It also makes end-of-interrupt writes with out-of-range IDs 6 and 7 reachable. Random priorities are drawn from 0 to 3, so ties and nested preemption occur often. The random masks land both on and just above those values, which exercises the strict mask comparison.

// File: rtl/prio_irq_hub_pkg.sv
package prio_irq_hub_pkg;
  localparam int ID_W        = 10;
  localparam int SPURIOUS_ID = 1023;
  localparam int REG_CTRL    = 0;
  localparam int REG_MASK    = 1;
  localparam int REG_ACK     = 2;
  localparam int REG_EOI     = 3;
  localparam int REG_SRCEN   = 4;
  localparam int REG_PRIO0   = 32;
endpackage

// File: rtl/prio_irq_hub_regs.sv
module prio_irq_hub_regs
  import prio_irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  output logic                      cpu_en,
  output logic [PRIO_W-1:0]         pmask,
  output logic [NUM_SRC-1:0]        src_en,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [DATA_W-1:0]         cfg_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_en <= 1'b0;
      pmask  <= '0;
      src_en <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(REG_CTRL))  cpu_en <= wr_data[0];
      if (addr == ADDR_W'(REG_MASK))  pmask  <= wr_data[PRIO_W-1:0];
      if (addr == ADDR_W'(REG_SRCEN)) src_en <= wr_data[NUM_SRC-1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n) prio_flat[i*PRIO_W +: PRIO_W] <= '0;
      else if (wr_en && addr == ADDR_W'(REG_PRIO0 + i))
        prio_flat[i*PRIO_W +: PRIO_W] <= wr_data[PRIO_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (addr == ADDR_W'(REG_CTRL))  cfg_rdata[0] = cpu_en;
    if (addr == ADDR_W'(REG_MASK))  cfg_rdata[PRIO_W-1:0] = pmask;
    if (addr == ADDR_W'(REG_SRCEN)) cfg_rdata[NUM_SRC-1:0] = src_en;
    for (int i = 0; i < NUM_SRC; i++)
      if (addr == ADDR_W'(REG_PRIO0 + i)) cfg_rdata[PRIO_W-1:0] = prio_flat[i*PRIO_W +: PRIO_W];
  end
endmodule

// File: rtl/prio_irq_hub_arb.sv
module prio_irq_hub_arb
  import prio_irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        active,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]         pmask,
  output logic                      win_valid,
  output logic [ID_W-1:0]           win_id
);
  logic              run_any;
  logic [PRIO_W-1:0] run_min;
  logic [NUM_SRC-1:0] cand;
  logic [PRIO_W-1:0] best;

  // running priority: most urgent among active sources
  always_comb begin
    run_any = 1'b0;
    run_min = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i] && (!run_any || prio_flat[i*PRIO_W +: PRIO_W] < run_min)) begin
        run_min = prio_flat[i*PRIO_W +: PRIO_W];
        run_any = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
    assign cand[i] = req[i] && src_en[i] && !active[i]
                  && (prio_flat[i*PRIO_W +: PRIO_W] < pmask)
                  && (!run_any || prio_flat[i*PRIO_W +: PRIO_W] < run_min);
  end

  // strict compare keeps the lowest ID on ties
  always_comb begin
    win_valid = 1'b0;
    win_id    = ID_W'(SPURIOUS_ID);
    best      = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
        best      = prio_flat[i*PRIO_W +: PRIO_W];
        win_id    = ID_W'(i);
        win_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_irq_hub_state.sv
module prio_irq_hub_state
  import prio_irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_take,
  input  logic [ID_W-1:0]    win_id,
  input  logic               eoi_wr,
  input  logic [ID_W-1:0]    eoi_id,
  output logic [NUM_SRC-1:0] active
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_act
    always_ff @(posedge clk) begin
      if (!rst_n) active[i] <= 1'b0;
      else if (ack_take && win_id == ID_W'(i)) active[i] <= 1'b1;
      else if (eoi_wr && eoi_id == ID_W'(i)) active[i] <= 1'b0;
    end

    // R6
    act_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active[i]) |-> ($past(ack_take) && $past(win_id) == ID_W'(i)));

    // R8
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && eoi_id == ID_W'(i) && !(ack_take && win_id == ID_W'(i))) |=> !active[i]);
  end

  // R6
  one_new_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active & ~$past(active)));
endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub
  import prio_irq_hub_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  logic                      cpu_en;
  logic [PRIO_W-1:0]         pmask;
  logic [NUM_SRC-1:0]        src_en;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [DATA_W-1:0]         cfg_rdata;
  logic [NUM_SRC-1:0]        active;
  logic                      win_valid;
  logic [ID_W-1:0]           win_id;
  logic                      ack_rd, ack_take, eoi_wr;

  assign ack_rd   = bus_rd && bus_addr == ADDR_W'(REG_ACK);
  assign ack_take = ack_rd && cpu_en && win_valid;
  assign eoi_wr   = bus_wr && bus_addr == ADDR_W'(REG_EOI);

  prio_irq_hub_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .wr_data(bus_wdata),
    .cpu_en(cpu_en), .pmask(pmask), .src_en(src_en), .prio_flat(prio_flat), .cfg_rdata(cfg_rdata));

  prio_irq_hub_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .req(irq_req), .src_en(src_en), .active(active), .prio_flat(prio_flat), .pmask(pmask),
    .win_valid(win_valid), .win_id(win_id));

  prio_irq_hub_state #(.NUM_SRC(NUM_SRC)) u_state (
    .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .win_id(win_id),
    .eoi_wr(eoi_wr), .eoi_id(bus_wdata[ID_W-1:0]), .active(active));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= cpu_en && win_valid;
      if (bus_rd) begin
        if (ack_rd) bus_rdata <= DATA_W'(ack_take ? win_id : ID_W'(SPURIOUS_ID));
        else        bus_rdata <= cfg_rdata;
      end
    end
  end

  // R2
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(cpu_en));

  // R7
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !win_valid) |=> bus_rdata[ID_W-1:0] == ID_W'(SPURIOUS_ID));

  // R5
  winner_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (win_id < ID_W'(NUM_SRC)));
endmodule

// File: tb/sim_prio_irq_hub.sv
module sim_prio_irq_hub;
  localparam int NS = 6;
  localparam int AW = 7;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq_o;

  always #10 clk = ~clk;

  prio_irq_hub #(.NUM_SRC(NS), .PRIO_W(8), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o));

  int checks = 0, errors = 0;
  bit m_en;
  int m_mask;
  bit [NS-1:0] m_srcen, m_act;
  int m_prio [NS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_win();
    int rmin = 256;
    int best = 256;
    int id = 1023;
    for (int i = 0; i < NS; i++) if (m_act[i] && m_prio[i] < rmin) rmin = m_prio[i];
    for (int i = 0; i < NS; i++)
      if (irq_req[i] && m_srcen[i] && !m_act[i] && m_prio[i] < m_mask && m_prio[i] < rmin && m_prio[i] < best) begin
        best = m_prio[i];
        id = i;
      end
    return id;
  endfunction

  function automatic bit model_irq();
    return m_en && model_win() != 1023;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = DW'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 0) m_en = d[0];
    if (a == 1) m_mask = d & 8'hFF;
    if (a == 4) m_srcen = NS'(d);
    if (a >= 32 && a < 32 + NS) m_prio[a-32] = d & 8'hFF;
    if (a == 3 && d < NS) m_act[d] = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic ack(input string tag);
    int exp, v;
    exp = m_en ? model_win() : 1023;
    rd(2, v);
    chk(v == exp, tag, v, exp);
    if (exp != 1023) m_act[exp] = 1'b1;
  endtask

  task automatic settle_irq(input string tag);
    repeat (2) @(negedge clk);
    chk(irq_o == model_irq(), tag, int'(irq_o), int'(model_irq()));
  endtask

  task automatic set_req(input bit [NS-1:0] r);
    @(negedge clk);
    irq_req = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd4242));
    m_en = 0; m_mask = 0; m_srcen = '0; m_act = '0;
    for (int i = 0; i < NS; i++) m_prio[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(1, v); chk(v == 0, "R1 mask", v, 0);
    rd(4, v); chk(v == 0, "R1 srcen", v, 0);
    rd(35, v); chk(v == 0, "R1 prio", v, 0);
    ack("R1 ack idle");

    // R9 readback and unmapped
    wr(1, 32'h5A); rd(1, v); chk(v == 32'h5A, "R9 mask", v, 32'h5A);
    wr(35, 32'hC3); rd(35, v); chk(v == 32'hC3, "R9 prio3", v, 32'hC3);
    wr(4, 32'h2D); rd(4, v); chk(v == 32'h2D, "R9 srcen", v, 32'h2D);
    wr(38, 32'h11); rd(38, v); chk(v == 0, "R9 unmapped", v, 0);

    // R2 enable gating
    for (int i = 0; i < NS; i++) wr(32 + i, 5);
    wr(4, 6'h3F); wr(1, 8'hFF);
    set_req(6'b000100);
    settle_irq("R2 disabled"); chk(irq_o == 0, "R2 low", int'(irq_o), 0);
    ack("R2 ack disabled");
    wr(0, 1);
    settle_irq("R2 enabled"); chk(irq_o == 1, "R2 high", int'(irq_o), 1);

    // R3 strict mask
    wr(1, 5); settle_irq("R3 equal"); chk(irq_o == 0, "R3 equal low", int'(irq_o), 0);
    wr(1, 6); settle_irq("R3 above"); chk(irq_o == 1, "R3 above high", int'(irq_o), 1);

    // R4 per-source enable
    wr(4, 6'h3B); settle_irq("R4 off"); chk(irq_o == 0, "R4 off low", int'(irq_o), 0);
    wr(4, 6'h3F);

    // R5 tie to lowest ID, R6 nesting
    wr(1, 8'hFF); wr(34, 3); wr(36, 3); wr(33, 1);
    set_req(6'b010100);
    ack("R5 tie"); chk(m_act[2], "R5 tie id2", int'(m_act), 4);
    settle_irq("R6 same prio blocked");
    set_req(6'b010110);
    settle_irq("R6 preempt"); chk(irq_o == 1, "R6 preempt high", int'(irq_o), 1);
    ack("R6 ack nested");
    ack("R7 spurious nested");
    // R8 EOI and re-raise
    wr(3, 7); settle_irq("R8 bad id");
    wr(3, 1); settle_irq("R8 eoi1");
    wr(3, 2); settle_irq("R8 eoi2 reraise"); chk(irq_o == 1, "R8 reraise high", int'(irq_o), 1);
    ack("R8 ack after eoi");
    wr(3, 2); wr(3, 1);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: set_req(NS'($urandom));
        2: wr(32 + $urandom_range(0, NS - 1), $urandom_range(0, 3));
        3: begin
          int mk = $urandom_range(0, 3);
          wr(1, mk == 0 ? 8'hFF : mk + 1);
        end
        4: wr(4, $urandom_range(0, 63));
        5, 6: ack("R5 R6 random ack");
        7, 8: wr(3, $urandom_range(0, 7));
        default: wr(0, ($urandom_range(0, 7) != 0) ? 1 : 0);
      endcase
      settle_irq("R10 random irq");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule